// File: doc/BRIEF.md
# Data Polling Status Responder

This block answers read cycles on the byte-wide bus of an electrically erasable memory model and reports the end of a programming cycle through the data itself. No separate ready/busy pin exists. Once a byte write is accepted, an internal programming cycle runs for `PROG_CYCLES` clocks. During that time every read returns the last accepted byte with bit 7 inverted. When the cycle ends, the byte is committed to the cell array and reads return the stored contents again.

A host-side poller is built into the same block. When `poll_start` is pulsed, the poller writes one byte. It then waits a programmable number of idle cycles, which models the host handing its time to other tasks. After that it reads back the same address and compares bit 7 with the byte it wrote. A mismatch means programming is still running, so the wait and the read are repeated. A match sets `poll_done`. If the number of reads reaches a programmable limit without a match, `poll_timeout` is set. While the poller is running it owns the memory bus, and the external bus pins are ignored.

Top module: `poll_status_unit`

## Requirements
- R1: After reset there is no programming cycle running and the poller is idle. `poll_done`, `poll_timeout` and `poll_count` are all 0, and every location reads as 8'hFF (erased).
- R2: The data output is enabled (`dq_oe`=1) only when `cs_n`=0, `oe_n`=0 and `we_n`=1. In every other combination (`cs_n`=1 is standby; `cs_n`=0 with `oe_n`=1 and `we_n`=1 is output off), `dq_oe` is 0 and `dq_out` is 8'h00.
- R3: When no programming cycle is running, a read returns the stored byte at `addr` in the same cycle.
- R4: A write is accepted at a clock edge where `cs_n`=0, `we_n`=0, `oe_n`=1 and no programming cycle is running. Programming then lasts exactly `PROG_CYCLES` cycles after that edge.
- R5: During programming, a read at any address returns the last accepted byte with bit 7 inverted and bits 6:0 unchanged.
- R6: At the end of programming the byte is stored at its address. From the next cycle on, a read returns it with bit 7 true.
- R7: A cycle with `cs_n`=0, `oe_n`=0 and `we_n`=0 is write-inhibited, and so is a cycle with `cs_n`=1 and `we_n`=0. Neither starts programming nor changes the array.
- R8: A write attempted during programming is ignored. The status byte and the contents of both the busy address and the attempted address are unchanged.
- R9: When started, the poller spends one cycle writing `poll_data` to `poll_addr`. It then inserts exactly `poll_gap` idle bus cycles before each read of `poll_addr`.
- R10: When a read's bit 7 equals bit 7 of `poll_data`, the poller sets `poll_done` and returns to idle. `poll_count` then equals the number of reads made.
- R11: If `poll_count` reaches `poll_max` without a match, `poll_timeout` is set and `poll_done` stays 0. A `poll_max` of 0 acts as 1.
- R12: While the poller is active (`poll_active`=1), the external bus pins and further `poll_start` pulses have no effect.
- R13: Accepting a start clears `poll_done`, `poll_timeout` and `poll_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | External chip select, active low |
| oe_n | input | 1 | External output enable, active low |
| we_n | input | 1 | External write enable, active low |
| addr | input | ADDR_W | External byte address |
| din | input | 8 | External write data |
| dq_out | output | 8 | Read data (0 when not driven) |
| dq_oe | output | 1 | Read data drive enable |
| poll_start | input | 1 | Start pulse for the poller |
| poll_addr | input | ADDR_W | Address the poller writes and polls |
| poll_data | input | 8 | Byte the poller writes |
| poll_max | input | POLL_W | Read limit before timeout |
| poll_gap | input | GAP_W | Idle cycles before each poll read |
| poll_active | output | 1 | Poller owns the bus |
| poll_done | output | 1 | Last poll ended with a bit-7 match |
| poll_timeout | output | 1 | Last poll hit the read limit |
| poll_count | output | POLL_W | Reads made by the last or current poll |

## Verification
Read data is combinational. A read is due in the same cycle the bus pins select it, and the status byte appears from the first cycle after the accepting edge. It lasts `PROG_CYCLES` cycles, and the true byte is due in the cycle that follows. The poller flags and count change one edge after the deciding read cycle. `poll_active` drops at that same edge. The bench drives its inputs on the falling edge and checks 1 ns later against a behavioural model that it advances on each rising edge. Every comparison therefore sees the values due for the current cycle.

// File: rtl/poll_pkg.sv
package poll_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ERASED = 8'hFF;

  typedef enum logic [2:0] {
    BUS_STANDBY,
    BUS_OFF,
    BUS_READ,
    BUS_WRITE,
    BUS_INHIBIT
  } bus_mode_e;

  typedef enum logic [1:0] {
    HP_IDLE,
    HP_WRITE,
    HP_GAP,
    HP_READ
  } hp_state_e;

  // Decode the three strobes into a bus mode.
  function automatic bus_mode_e decode_bus(logic cs_n, logic oe_n, logic we_n);
    if (cs_n)             return BUS_STANDBY;
    if (!oe_n &&  we_n)   return BUS_READ;
    if ( oe_n && !we_n)   return BUS_WRITE;
    if (!oe_n && !we_n)   return BUS_INHIBIT;
    return BUS_OFF;
  endfunction

  // Byte shown while programming: bit 7 inverted.
  function automatic logic [BYTE_W-1:0] status_byte(logic [BYTE_W-1:0] d);
    return {~d[BYTE_W-1], d[BYTE_W-2:0]};
  endfunction

  // Read limit test; a limit of zero behaves as one.
  function automatic logic limit_hit(int unsigned n, int unsigned lim);
    if (lim == 0) return (n >= 1);
    return (n >= lim);
  endfunction

endpackage

// File: rtl/bus_mode_decode.sv
module bus_mode_decode
  import poll_pkg::*;
(
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_en,
  output logic wr_req
);

  bus_mode_e mode;

  always_comb begin
    mode   = decode_bus(cs_n, oe_n, we_n);
    rd_en  = (mode == BUS_READ);
    wr_req = (mode == BUS_WRITE);
  end

endmodule

// File: rtl/prog_engine.sv
module prog_engine
  import poll_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int PROG_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              busy,
  output logic              commit,
  output logic              fire,
  output logic [ADDR_W-1:0] last_addr,
  output logic [BYTE_W-1:0] last_data
);

  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0]     left_q;
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;

  assign fire      = wr_req && !busy_q;
  assign commit    = busy_q && (left_q == CW'(1));
  assign busy      = busy_q;
  assign last_addr = addr_q;
  assign last_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (fire) begin
      busy_q <= 1'b1;
      left_q <= CW'(PROG_CYCLES);
      addr_q <= wr_addr;
      data_q <= wr_data;
    end else if (busy_q) begin
      left_q <= left_q - CW'(1);
      if (left_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  // R4: an accepted write starts programming and captures its byte
  p_fire_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (busy && last_data == $past(wr_data) && last_addr == $past(wr_addr)));

  // R8: a write request during programming leaves the captured byte alone
  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_req) |=> ($stable(last_data) && $stable(last_addr)));

endmodule

// File: rtl/cell_array.sv
module cell_array
  import poll_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [BYTE_W-1:0] commit_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= ERASED;
    end else if (commit) begin
      cell_q[commit_addr] <= commit_data;
    end
  end

  assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/read_responder.sv
module read_responder
  import poll_pkg::*;
(
  input  logic              rd_en,
  input  logic              busy,
  input  logic [BYTE_W-1:0] last_data,
  input  logic [BYTE_W-1:0] cell_data,
  output logic [BYTE_W-1:0] dq_out,
  output logic              dq_oe
);

  always_comb begin
    dq_oe  = rd_en;
    dq_out = '0;
    if (rd_en) dq_out = busy ? status_byte(last_data) : cell_data;
  end

endmodule

// File: rtl/host_poller.sv
module host_poller
  import poll_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int POLL_W = 8,
  parameter int GAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [BYTE_W-1:0] start_data,
  input  logic [POLL_W-1:0] max_polls,
  input  logic [GAP_W-1:0]  idle_gap,
  input  logic              rd_msb,
  output logic              bus_cs_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_data,
  output logic              active,
  output logic              done,
  output logic              timeout,
  output logic [POLL_W-1:0] count
);

  hp_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;
  logic [POLL_W-1:0] max_q;
  logic [GAP_W-1:0]  gap_q;
  logic [GAP_W-1:0]  gcnt_q;
  logic [POLL_W-1:0] reads_q;
  logic              done_q;
  logic              tmo_q;

  logic [POLL_W-1:0] reads_nx;
  logic              bit_match;
  logic              give_up;

  assign reads_nx  = reads_q + POLL_W'(1);
  assign bit_match = (rd_msb == data_q[BYTE_W-1]);
  assign give_up   = limit_hit(32'(reads_nx), 32'(max_q));

  always_comb begin
    bus_cs_n = 1'b1;
    bus_oe_n = 1'b1;
    bus_we_n = 1'b1;
    case (state_q)
      HP_WRITE: begin bus_cs_n = 1'b0; bus_we_n = 1'b0; end
      HP_READ:  begin bus_cs_n = 1'b0; bus_oe_n = 1'b0; end
      default:  ;
    endcase
  end

  assign bus_addr = addr_q;
  assign bus_data = data_q;
  assign active   = (state_q != HP_IDLE);
  assign done     = done_q;
  assign timeout  = tmo_q;
  assign count    = reads_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HP_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      max_q   <= '0;
      gap_q   <= '0;
      gcnt_q  <= '0;
      reads_q <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      case (state_q)
        HP_IDLE: if (start) begin
          addr_q  <= start_addr;
          data_q  <= start_data;
          max_q   <= max_polls;
          gap_q   <= idle_gap;
          reads_q <= '0;
          done_q  <= 1'b0;
          tmo_q   <= 1'b0;
          state_q <= HP_WRITE;
        end
        HP_WRITE: begin
          if (gap_q == '0) state_q <= HP_READ;
          else begin
            gcnt_q  <= gap_q - GAP_W'(1);
            state_q <= HP_GAP;
          end
        end
        HP_GAP: begin
          if (gcnt_q == '0) state_q <= HP_READ;
          else gcnt_q <= gcnt_q - GAP_W'(1);
        end
        HP_READ: begin
          reads_q <= reads_nx;
          if (bit_match) begin
            done_q  <= 1'b1;
            state_q <= HP_IDLE;
          end else if (give_up) begin
            tmo_q   <= 1'b1;
            state_q <= HP_IDLE;
          end else if (gap_q == '0) begin
            state_q <= HP_READ;
          end else begin
            gcnt_q  <= gap_q - GAP_W'(1);
            state_q <= HP_GAP;
          end
        end
        default: state_q <= HP_IDLE;
      endcase
    end
  end

  // R9: the single write cycle is always followed by waiting or reading
  p_write_then_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HP_WRITE) |=> (state_q == HP_GAP || state_q == HP_READ));

  // R10: completion is only ever reported after a read cycle
  p_done_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(state_q == HP_READ));

  // R11: done and timeout never both set
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && tmo_q));

  // R11: the read count never passes a nonzero limit
  p_reads_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (max_q != '0) |-> (reads_q <= max_q));

endmodule

// File: rtl/poll_status_unit.sv
module poll_status_unit
  import poll_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int PROG_CYCLES = 12,
  parameter int POLL_W      = 8,
  parameter int GAP_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  input  logic              poll_start,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic [7:0]        poll_data,
  input  logic [POLL_W-1:0] poll_max,
  input  logic [GAP_W-1:0]  poll_gap,
  output logic              poll_active,
  output logic              poll_done,
  output logic              poll_timeout,
  output logic [POLL_W-1:0] poll_count
);

  // Poller-side bus
  logic              p_cs_n, p_oe_n, p_we_n;
  logic [ADDR_W-1:0] p_addr;
  logic [BYTE_W-1:0] p_data;

  // Effective bus seen by the memory side
  logic              e_cs_n, e_oe_n, e_we_n;
  logic [ADDR_W-1:0] e_addr;
  logic [BYTE_W-1:0] e_data;

  logic              rd_en, wr_req;
  logic              busy, commit, fire;
  logic [ADDR_W-1:0] last_addr;
  logic [BYTE_W-1:0] last_data;
  logic [BYTE_W-1:0] cell_data;

  assign e_cs_n = poll_active ? p_cs_n : cs_n;
  assign e_oe_n = poll_active ? p_oe_n : oe_n;
  assign e_we_n = poll_active ? p_we_n : we_n;
  assign e_addr = poll_active ? p_addr : addr;
  assign e_data = poll_active ? p_data : din;

  bus_mode_decode u_decode (
    .cs_n   (e_cs_n),
    .oe_n   (e_oe_n),
    .we_n   (e_we_n),
    .rd_en  (rd_en),
    .wr_req (wr_req)
  );

  prog_engine #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .wr_addr   (e_addr),
    .wr_data   (e_data),
    .busy      (busy),
    .commit    (commit),
    .fire      (fire),
    .last_addr (last_addr),
    .last_data (last_data)
  );

  cell_array #(.ADDR_W(ADDR_W)) u_cells (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_addr (last_addr),
    .commit_data (last_data),
    .rd_addr     (e_addr),
    .rd_data     (cell_data)
  );

  read_responder u_resp (
    .rd_en     (rd_en),
    .busy      (busy),
    .last_data (last_data),
    .cell_data (cell_data),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  host_poller #(.ADDR_W(ADDR_W), .POLL_W(POLL_W), .GAP_W(GAP_W)) u_poller (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (poll_start),
    .start_addr (poll_addr),
    .start_data (poll_data),
    .max_polls  (poll_max),
    .idle_gap   (poll_gap),
    .rd_msb     (dq_out[BYTE_W-1]),
    .bus_cs_n   (p_cs_n),
    .bus_oe_n   (p_oe_n),
    .bus_we_n   (p_we_n),
    .bus_addr   (p_addr),
    .bus_data   (p_data),
    .active     (poll_active),
    .done       (poll_done),
    .timeout    (poll_timeout),
    .count      (poll_count)
  );

  // R7: output enable low with chip select low never yields a write
  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!e_cs_n && !e_oe_n) |-> !fire);

  // R5: a read during programming shows bit 7 opposite to the held byte
  p_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_oe) |-> (dq_out[7] != last_data[7] && dq_out[6:0] == last_data[6:0]));

  // R6: the commit edge ends programming
  p_commit_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  // R2: nothing is driven unless the strobes select a read
  p_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

endmodule

// File: tb/poll_status_unit_test.sv
`timescale 1ns/1ps
module poll_status_unit_test;

  localparam int AW   = 4;
  localparam int PROG = 12;
  localparam int PW   = 8;
  localparam int GW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic pstart = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [7:0] pdata = '0;
  logic [PW-1:0] pmax = '0;
  logic [GW-1:0] pgap = '0;
  wire [7:0] dq_out;
  wire dq_oe, p_act, p_done, p_tmo;
  wire [PW-1:0] p_cnt;

  always #2.5 clk = ~clk;

  poll_status_unit #(.ADDR_W(AW), .PROG_CYCLES(PROG), .POLL_W(PW), .GAP_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
    .poll_start(pstart), .poll_addr(paddr), .poll_data(pdata),
    .poll_max(pmax), .poll_gap(pgap), .poll_active(p_act),
    .poll_done(p_done), .poll_timeout(p_tmo), .poll_count(p_cnt));

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [16];
  bit   m_busy;
  int   m_left;
  int   m_laddr;
  logic [7:0] m_ldata;
  int   m_pst;          // 0 idle, 1 write, 2 wait, 3 read
  int   m_gleft, m_reads, m_pmax, m_pgap, m_paddr;
  logic [7:0] m_pdata;
  bit   m_done, m_tmo;

  logic e_cs, e_oe, e_we, e_rd, e_wr;
  int   e_addr;
  logic [7:0] e_din, e_val, exp_dq;

  always @* begin
    if (m_pst == 1) begin
      e_cs = 0; e_oe = 1; e_we = 0; e_addr = m_paddr; e_din = m_pdata;
    end else if (m_pst == 2) begin
      e_cs = 1; e_oe = 1; e_we = 1; e_addr = m_paddr; e_din = m_pdata;
    end else if (m_pst == 3) begin
      e_cs = 0; e_oe = 0; e_we = 1; e_addr = m_paddr; e_din = m_pdata;
    end else begin
      e_cs = cs_n; e_oe = oe_n; e_we = we_n; e_addr = int'(addr); e_din = din;
    end
    e_rd   = !e_cs && !e_oe && e_we;
    e_wr   = !e_cs && !e_we && e_oe;
    e_val  = m_busy ? (m_ldata ^ 8'h80) : m_mem[e_addr];
    exp_dq = e_rd ? e_val : 8'h00;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_mem[i] <= 8'hFF;
      m_busy <= 0; m_left <= 0; m_laddr <= 0; m_ldata <= 0;
      m_pst <= 0; m_gleft <= 0; m_reads <= 0; m_pmax <= 0; m_pgap <= 0;
      m_paddr <= 0; m_pdata <= 0; m_done <= 0; m_tmo <= 0;
    end else begin
      if (e_wr && !m_busy) begin
        m_busy <= 1; m_left <= PROG; m_laddr <= e_addr; m_ldata <= e_din;
      end else if (m_busy) begin
        m_left <= m_left - 1;
        if (m_left == 1) begin
          m_busy <= 0;
          m_mem[m_laddr] <= m_ldata;
        end
      end
      case (m_pst)
        0: if (pstart) begin
          m_paddr <= int'(paddr); m_pdata <= pdata; m_pmax <= int'(pmax);
          m_pgap <= int'(pgap); m_reads <= 0; m_done <= 0; m_tmo <= 0; m_pst <= 1;
        end
        1: begin
          if (m_pgap == 0) m_pst <= 3;
          else begin m_pst <= 2; m_gleft <= m_pgap; end
        end
        2: begin
          if (m_gleft <= 1) m_pst <= 3;
          else m_gleft <= m_gleft - 1;
        end
        default: begin
          m_reads <= m_reads + 1;
          if (e_val[7] == m_pdata[7]) begin
            m_done <= 1; m_pst <= 0;
          end else if (m_reads + 1 >= ((m_pmax == 0) ? 1 : m_pmax)) begin
            m_tmo <= 1; m_pst <= 0;
          end else if (m_pgap == 0) m_pst <= 3;
          else begin m_pst <= 2; m_gleft <= m_pgap; end
        end
      endcase
    end
  end

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      #1;
      chk(e_rd ? (m_busy ? "R5 status byte" : "R3 array read") : "R2 drive enable",
          int'(dq_oe), int'(e_rd));
      chk(e_rd ? (m_busy ? "R5 status byte" : "R3 array read") : "R2 idle data",
          int'(dq_out), int'(exp_dq));
      chk("R9 poll_active", int'(p_act), int'(m_pst != 0));
      chk("R10 poll_done", int'(p_done), int'(m_done));
      chk("R11 poll_timeout", int'(p_tmo), int'(m_tmo));
      chk("R10 poll_count", int'(p_cnt), m_reads);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(logic c, logic o, logic w, int a, logic [7:0] d);
    @(negedge clk);
    cs_n = c; oe_n = o; we_n = w; addr = AW'(a); din = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1, 1, 1, 0, 8'h00);
  endtask

  task automatic start_poll(int a, logic [7:0] d, int mx, int gp);
    @(negedge clk);
    paddr = AW'(a); pdata = d; pmax = PW'(mx); pgap = GW'(gp); pstart = 1;
    @(negedge clk);
    pstart = 0;
    #1;
    chk("R13 done cleared", int'(p_done), 0);
    chk("R13 timeout cleared", int'(p_tmo), 0);
    chk("R13 count cleared", int'(p_cnt), 0);
  endtask

  task automatic wait_poll(bit ext_noise);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!p_act) break;
      if (ext_noise) begin
        cs_n = 0; oe_n = 1; we_n = 0; addr = 4'd9; din = 8'h12;
        pstart = (i == 3);
      end
    end
    cs_n = 1; oe_n = 1; we_n = 1; pstart = 0;
  endtask

  initial begin
    int inv_cnt;
    int first_true;
    idle(3);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 poll_active", int'(p_act), 0);
    chk("R1 poll_done", int'(p_done), 0);
    chk("R1 poll_timeout", int'(p_tmo), 0);
    chk("R1 poll_count", int'(p_cnt), 0);
    for (int a = 0; a < 16; a++) begin
      drive(0, 0, 1, a, 8'h00); #1;
      chk("R1 erased read", int'(dq_out), 8'hFF);
    end

    // R2: standby and output-off
    drive(1, 0, 1, 2, 8'h00); #1;
    chk("R2 standby oe", int'(dq_oe), 0);
    drive(0, 1, 1, 2, 8'h00); #1;
    chk("R2 output off oe", int'(dq_oe), 0);
    chk("R2 output off data", int'(dq_out), 0);

    // R7: inhibited writes
    drive(0, 0, 0, 5, 8'h11);
    drive(1, 1, 0, 5, 8'h22);
    drive(0, 0, 1, 5, 8'h00); #1;
    chk("R7 inhibit no write", int'(dq_out), 8'hFF);

    // R4/R5/R6: single write, read through programming
    drive(0, 1, 0, 3, 8'h5A);
    inv_cnt = 0; first_true = -1;
    for (int i = 0; i < 20; i++) begin
      drive(0, 0, 1, (i == 0) ? 3 : (i % 16), 8'h00); #1;
      if (i == 0) chk("R5 first status read", int'(dq_out), 8'hDA);
      if (dq_out == 8'hDA) inv_cnt++;
    end
    chk("R4 programming length", inv_cnt, PROG);
    for (int i = 0; i < 14; i++) begin
      drive(0, 0, 1, 3, 8'h00); #1;
      if (dq_out == 8'h5A && first_true < 0) first_true = i;
    end
    chk("R6 committed byte", int'(dq_out), 8'h5A);
    chk("R6 true from first idle read", first_true, 0);

    // R8: write during programming ignored
    drive(0, 1, 0, 3, 8'h81);
    drive(0, 1, 0, 7, 8'h00);
    drive(0, 0, 1, 7, 8'h00); #1;
    chk("R8 status unchanged", int'(dq_out), 8'h01);
    idle(PROG + 2);
    drive(0, 0, 1, 7, 8'h00); #1;
    chk("R8 ignored address", int'(dq_out), 8'hFF);
    drive(0, 0, 1, 3, 8'h00); #1;
    chk("R8 busy address kept", int'(dq_out), 8'h81);

    // R9/R10/R12: poll with gap 2 and external noise
    idle(2);
    start_poll(6, 8'hC3, 20, 2);
    wait_poll(1);
    #1;
    chk("R10 done set", int'(p_done), 1);
    chk("R10 timeout clear", int'(p_tmo), 0);
    chk("R10 read count", int'(p_cnt), 5);
    idle(2);
    drive(0, 0, 1, 9, 8'h00); #1;
    chk("R12 external write ignored", int'(dq_out), 8'hFF);
    drive(0, 0, 1, 6, 8'h00); #1;
    chk("R10 polled byte stored", int'(dq_out), 8'hC3);

    // R11: timeout with limit 2, no gap
    idle(2);
    start_poll(1, 8'h80, 2, 0);
    wait_poll(0);
    #1;
    chk("R11 timeout set", int'(p_tmo), 1);
    chk("R11 done clear", int'(p_done), 0);
    chk("R11 count at limit", int'(p_cnt), 2);

    // R11: limit 0 acts as 1
    idle(PROG + 4);
    start_poll(2, 8'h7F, 0, 1);
    wait_poll(0);
    #1;
    chk("R11 zero limit timeout", int'(p_tmo), 1);
    chk("R11 zero limit count", int'(p_cnt), 1);

    // Poll with bit 7 low, long gap
    idle(PROG + 4);
    start_poll(4, 8'h3C, 50, 5);
    wait_poll(0);
    #1;
    chk("R10 done bit7 low", int'(p_done), 1);
    chk("R10 count bit7 low", int'(p_cnt), 3);

    idle(4);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule